// File: doc/BRIEF.md
# Exponent Third-Split and Root Rescaler

This block is one stage of a floating-point cube root datapath. A root core delivers the cube root of a normalized mantissa as a 32-bit fraction. This stage folds the input's exponent into that result. It takes the 8-bit biased exponent of the operand, removes the bias and the 23-bit integer scaling of the mantissa, and divides the magnitude of the resulting working exponent by three. The quotient becomes the partial exponent of the result. A nonzero remainder is absorbed into the mantissa by multiplying the root by a constant that stands for a fractional power of two. The product is then renormalized into [0.5, 1), and the partial exponent is corrected to match.

The result meets value(out) = out_mant / 2^32 × 2^out_pexp ≈ in_root / 2^32 × 2^(E/3), where E is the working exponent. Special operands and rounding are handled by other stages.

Both sides are valid/ready streams, and there is one register stage between them. A beat is accepted on a clock edge where in_valid and in_ready are both high. in_ready is high whenever the output register is empty or is being drained in the same cycle. A downstream stall therefore propagates back to the input in the same cycle. While out_valid is high and out_ready is low, the output holds its value.

Top module: `cbrt_exp_rescale`

## Requirements
- R1: The working exponent is E = in_bexp − 150. Its magnitude |E| splits into a quotient n = |E| / 3 and a remainder r = |E| mod 3.
- R2: When r = 0, out_mant equals in_root unchanged. out_pexp is n when E ≥ 0 and −n when E < 0, as 8-bit two's complement.
- R3: When r ≠ 0 and E ≥ 0, the root is multiplied by the Q0.24 constant 24'hA14517 (cube root of 2, halved) for r = 1, or 24'hCB2FF5 (cube root of 4, halved) for r = 2. The product is 56 bits wide.
- R4: When r ≠ 0 and E < 0, the constant is 24'hCB2FF5 (reciprocal cube root of 2) for r = 1 and 24'hA14517 (reciprocal cube root of 4) for r = 2.
- R5: For r ≠ 0, the base exponent is n when E ≥ 0 and −n−1 when E < 0. If bit 55 of the product is set, out_mant = product[55:24] and out_pexp = base + 1. Otherwise out_mant = product[54:23] and out_pexp = base.
- R6: A beat accepted on one edge appears on the outputs after that edge, with out_valid high. While out_valid is high and out_ready is low, out_valid, out_mant and out_pexp stay unchanged.
- R7: While reset is asserted, out_valid is low and in_ready is high.
- R8: in_root must have its two top bits set. Every output beat then has out_mant bit 31 set.
- R9: While out_ready is held high, in_ready stays high, so one beat is accepted on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Stage can take a beat |
| in_bexp | input | 8 | Biased exponent of the operand |
| in_root | input | 32 | Root from the core, fraction in [0.75, 1) |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_mant | output | 32 | Rescaled mantissa, fraction in [0.5, 1) |
| out_pexp | output | 8 | Signed partial exponent |

## Verification
Every result is due at the outputs one clock after the edge on which its beat was accepted. The bench drives inputs at the falling edge. It decides acceptance and consumption from the handshake signals sampled just after that edge, and compares each consumed beat, in order, against a model of the exponent split and constant product. After each stalled cycle, the bench checks that the held beat did not change. It also checks that out_valid rises on the cycle after every acceptance.

// File: rtl/cbrt_scale_pkg.sv
package cbrt_scale_pkg;
  // Width of the rescale constants (unsigned Q0.24 fractions).
  localparam int K_W = 24;
  // 2^(1/3)/2, identical in value to 2^(-2/3).
  localparam logic [K_W-1:0] K_THIRD  = 24'hA14517;
  // 2^(2/3)/2, identical in value to 2^(-1/3).
  localparam logic [K_W-1:0] K_TWO_TH = 24'hCB2FF5;

  typedef enum logic [1:0] {
    REM_ZERO = 2'd0,
    REM_ONE  = 2'd1,
    REM_TWO  = 2'd2
  } rem_e;
endpackage

// File: rtl/cbrt_exp_split.sv
module cbrt_exp_split #(
  parameter int EXP_W      = 8,
  parameter int BIAS       = 127,
  parameter int FRAC_SHIFT = 23,
  localparam int MAG_W     = EXP_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EXP_W-1:0] bexp,
  output logic             neg,
  output logic [MAG_W-1:0] quo,
  output cbrt_scale_pkg::rem_e rem
);
  localparam logic [MAG_W-1:0] OFFS = MAG_W'(BIAS + FRAC_SHIFT);

  logic [MAG_W-1:0] bext;
  logic [MAG_W-1:0] mag;
  logic [1:0]       part [MAG_W+1];

  assign bext = MAG_W'(bexp);
  assign neg  = bext < OFFS;
  assign mag  = neg ? (OFFS - bext) : (bext - OFFS);

  // Restoring long division by three, one stage per magnitude bit.
  assign part[MAG_W] = 2'd0;
  for (genvar i = MAG_W - 1; i >= 0; i--) begin : g_div
    logic [2:0] trial;
    assign trial   = {part[i+1], mag[i]};
    assign quo[i]  = trial >= 3'd3;
    assign part[i] = quo[i] ? 2'(trial - 3'd3) : trial[1:0];
  end

  assign rem = cbrt_scale_pkg::rem_e'(part[0]);

  AST_SPLIT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    ((MAG_W+2)'(quo) * 3 + (MAG_W+2)'(part[0])) == (MAG_W+2)'(mag)); // R1
  AST_REM_BELOW3: assert property (@(posedge clk) disable iff (!rst_n)
    part[0] != 2'd3); // R1
endmodule

// File: rtl/cbrt_const_sel.sv
module cbrt_const_sel
  import cbrt_scale_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  rem_e           rem,
  input  logic           neg,
  output logic [K_W-1:0] kval
);
  // Raising by 1/3 on the positive side equals lowering by 2/3 on the
  // negative side after the base exponent shift, so the pair swaps.
  function automatic logic [K_W-1:0] pick(input rem_e r, input logic n);
    case (r)
      REM_ONE: pick = n ? K_TWO_TH : K_THIRD;
      REM_TWO: pick = n ? K_THIRD  : K_TWO_TH;
      default: pick = '0;
    endcase
  endfunction

  assign kval = pick(rem, neg);

  AST_CONST_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (rem != REM_ZERO) |-> kval[K_W-1]); // R3
endmodule

// File: rtl/cbrt_renorm.sv
module cbrt_renorm #(
  parameter int ROOT_W = 32,
  parameter int PROD_W = 56
) (
  input  logic [PROD_W-1:0] prod,
  output logic [ROOT_W-1:0] mant,
  output logic              in_range
);
  assign in_range = prod[PROD_W-1];
  assign mant     = in_range ? prod[PROD_W-1 -: ROOT_W]
                             : prod[PROD_W-2 -: ROOT_W];
endmodule

// File: rtl/cbrt_exp_rescale.sv
module cbrt_exp_rescale
  import cbrt_scale_pkg::*;
#(
  parameter int EXP_W      = 8,
  parameter int BIAS       = 127,
  parameter int FRAC_SHIFT = 23,
  parameter int ROOT_W     = 32,
  parameter int PEXP_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [EXP_W-1:0]  in_bexp,
  input  logic [ROOT_W-1:0] in_root,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ROOT_W-1:0] out_mant,
  output logic [PEXP_W-1:0] out_pexp
);
  localparam int MAG_W  = EXP_W + 1;
  localparam int PROD_W = ROOT_W + K_W;

  logic              neg;
  logic [MAG_W-1:0]  quo;
  rem_e              rem;
  logic [K_W-1:0]    kval;
  logic [PROD_W-1:0] prod;
  logic [ROOT_W-1:0] norm_mant;
  logic              in_range;
  logic [PEXP_W-1:0] n_ext, pexp_zero, pexp_base, pexp_nxt;
  logic [ROOT_W-1:0] mant_nxt;

  cbrt_exp_split #(.EXP_W(EXP_W), .BIAS(BIAS), .FRAC_SHIFT(FRAC_SHIFT)) u_split (
    .clk(clk), .rst_n(rst_n), .bexp(in_bexp), .neg(neg), .quo(quo), .rem(rem));

  cbrt_const_sel u_sel (
    .clk(clk), .rst_n(rst_n), .rem(rem), .neg(neg), .kval(kval));

  assign prod = PROD_W'(in_root) * PROD_W'(kval);

  cbrt_renorm #(.ROOT_W(ROOT_W), .PROD_W(PROD_W)) u_norm (
    .prod(prod), .mant(norm_mant), .in_range(in_range));

  assign n_ext     = PEXP_W'(quo);
  assign pexp_zero = neg ? (~n_ext) + PEXP_W'(1) : n_ext;
  assign pexp_base = neg ? ~n_ext : n_ext;
  assign pexp_nxt  = (rem == REM_ZERO) ? pexp_zero : pexp_base + PEXP_W'(in_range);
  assign mant_nxt  = (rem == REM_ZERO) ? in_root : norm_mant;

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_mant  <= '0;
      out_pexp  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_mant <= mant_nxt;
        out_pexp <= pexp_nxt;
      end
    end
  end

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_mant) && $stable(out_pexp))); // R6
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid); // R6
  AST_ROOT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (in_root[ROOT_W-1 -: 2] == 2'b11)); // R8
  AST_MANT_NORM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_mant[ROOT_W-1]); // R8
  AST_PROD_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rem != REM_ZERO) |-> (prod[PROD_W-1] || prod[PROD_W-2])); // R5
endmodule

// File: tb/tb_cbrt_exp_rescale.sv
`timescale 1ns/1ps
module tb_cbrt_exp_rescale;
  localparam int ND    = 12;
  localparam int NRAND = 300;
  localparam int TOTAL = ND + NRAND;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [7:0]  in_bexp, out_pexp;
  logic [31:0] in_root, out_mant;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  cbrt_exp_rescale dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bexp(in_bexp), .in_root(in_root), .out_valid(out_valid),
    .out_ready(out_ready), .out_mant(out_mant), .out_pexp(out_pexp));

  logic [31:0] exp_mant [TOTAL];
  logic [7:0]  exp_pexp [TOTAL];
  string       exp_tag  [TOTAL];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Model: R1 split, R2 zero remainder, R3/R4 constants, R5 renormalization.
  function automatic logic [39:0] model(input logic [7:0] b, input logic [31:0] rt, output string tag);
    int e, mag, n, r, pe;
    logic neg;
    logic [63:0] k, p;
    logic [31:0] m;
    e = int'(b) - 150;
    neg = e < 0;
    mag = neg ? -e : e;
    n = mag / 3;
    r = mag % 3;
    if (r == 0) begin
      m = rt; pe = neg ? -n : n; tag = "R2";
    end else begin
      k = (((r == 2) ? 1'b1 : 1'b0) != neg) ? 64'hCB2FF5 : 64'hA14517;
      tag = neg ? "R4" : "R3";
      p = 64'(rt) * k;
      pe = neg ? -n - 1 : n;
      if (p[55]) begin m = p[55:24]; pe = pe + 1; end
      else m = p[54:23];
    end
    return {8'(pe), m};
  endfunction

  function automatic logic [39:0] pick(input int i);
    case (i)
      0: return {8'd150, 32'hC0000000};
      1: return {8'd151, 32'hFFFFFFFF};
      2: return {8'd152, 32'hC0000000};
      3: return {8'd153, 32'hE0000000};
      4: return {8'd149, 32'hC0000000};
      5: return {8'd148, 32'hFFFFFFFF};
      6: return {8'd147, 32'hD0000000};
      7: return {8'd0,   32'hC8000000};
      8: return {8'd255, 32'hF0000000};
      9: return {8'd1,   32'hC0000001};
      10: return {8'd254, 32'hFFFFFFFF};
      11: return {8'd146, 32'hC0000000};
      default: return {8'($urandom), 2'b11, 30'($urandom)};
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int sent = 0, wr = 0, rd = 0;
    logic pending = 1'b0, prev_stall = 1'b0, prev_acc = 1'b0;
    logic [31:0] prev_mant;
    logic [7:0]  prev_pexp;
    logic [39:0] item, ex;
    string tg;
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_bexp = '0; in_root = '0;
    repeat (4) @(negedge clk);
    #1;
    check("R7 out_valid in reset", 64'(out_valid), 64'd0);
    check("R7 in_ready in reset", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    while (rd < TOTAL) begin
      @(negedge clk);
      #1;
      if (prev_stall) begin
        check("R6 held valid", 64'(out_valid), 64'd1);
        check("R6 held mant", 64'(out_mant), 64'(prev_mant));
        check("R6 held pexp", 64'(out_pexp), 64'(prev_pexp));
      end
      if (prev_acc) check("R6 valid after accept", 64'(out_valid), 64'd1);
      if (sent < TOTAL && !pending) begin
        item = pick(sent);
        in_bexp = item[39:32];
        in_root = item[31:0];
        pending = 1'b1;
      end
      in_valid  = pending && (sent < ND || ($urandom % 4) != 0);
      out_ready = (sent < ND + 40 || sent >= TOTAL) ? 1'b1 : (($urandom % 3) != 0);
      #1;
      if (sent < ND + 40 && in_valid) check("R9 ready while drained", 64'(in_ready), 64'd1);
      prev_acc = in_valid && in_ready;
      if (prev_acc) begin
        ex = model(in_bexp, in_root, tg);
        exp_mant[wr] = ex[31:0];
        exp_pexp[wr] = ex[39:32];
        exp_tag[wr]  = tg;
        wr++; sent++; pending = 1'b0;
      end
      if (out_valid && out_ready) begin
        if (rd >= wr) check("R6 spurious beat", 64'd1, 64'd0);
        else begin
          check({exp_tag[rd], " mant"}, 64'(out_mant), 64'(exp_mant[rd]));
          check("R1/R5 pexp", 64'(out_pexp), 64'(exp_pexp[rd]));
          check("R8 mant msb", 64'(out_mant[31]), 64'd1);
        end
        rd++;
      end
      prev_stall = out_valid && !out_ready;
      prev_mant  = out_mant;
      prev_pexp  = out_pexp;
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule